// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Bus Link

This block joins one bus master and a set of memory-backed slaves over an unclocked word bus. A transfer is a fully interlocked return-to-zero exchange: the master puts the address, the direction and (for a write) the data on the shared lines and holds them steady. It lets a fixed number of its own clock cycles pass so that every slave can decode the address. Only then does it raise the request. The addressed slave answers with an acknowledge. The master drops the request, the slave drops the acknowledge, and the bus is free again.

Master and slaves each run on their own clock, and the two clocks need not be related. Each side is a small clocked state machine. It samples the other side's strobe through a two-flop synchronizer. Local commands enter the master through a valid/ready port. The port accepts a command on an edge where both valid and ready are high. Ready stays low for the whole exchange, so a waiting command must hold valid and its fields steady until it is taken. Completion comes back as a one-cycle pulse that cannot be stalled, with the read word beside it.

Each slave owns a window of `SLV_DEPTH` consecutive word addresses. Slave number k serves the addresses from k*SLV_DEPTH to k*SLV_DEPTH + SLV_DEPTH - 1. Undriven data lines resolve to zero.

Top module: `asb_link`

## Requirements
- R1: While reset is held and in the first cycle after it, cmd_ready is 1, and rsp_valid, bus_req_o and bus_ack_o are 0.
- R2: A command is taken on a clk_m edge with cmd_valid and cmd_ready both 1. From the next cycle, cmd_ready stays 0 until the cycle of the completion pulse. A command held valid during that time is taken exactly once, after the pulse.
- R3: From the cycle after acceptance until the completion pulse, bus_addr_o and bus_write_o (1 = write, 0 = read) hold the accepted values. During a write, bus_data_o holds the accepted write word over the same span.
- R4: bus_req_o rises exactly SETTLE_CYCLES clk_m cycles after the address first appears on the bus (default 2).
- R5: A write stores the word in the addressed slave location before acknowledge rises. A later read of that address returns the newest word written there.
- R6: On a read, the slave puts the stored word on the data lines no later than its acknowledge rises. The master returns that word on rsp_rdata with the completion pulse. A location never written reads as 0.
- R7: The exchange is interlocked. Acknowledge rises only while request is high. Request falls only after acknowledge is high. Acknowledge falls only after request is low.
- R8: A slave drives the data lines only when it is addressed, the direction is read, and its acknowledge is high. At most one agent drives the data lines at a time. When nobody drives them they read 0.
- R9: rsp_valid is a single-cycle pulse. It is raised only after the master has seen acknowledge low, so request and acknowledge are both 0 while rsp_valid is 1.
- R10: Address bits above the window index select the slave. A transfer touches only the selected slave's location, and addresses at both edges of each window work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Master clock |
| rst_m_n | input | 1 | Master reset, active low |
| clk_s | input | 1 | Slave clock, unrelated to clk_m |
| rst_s_n | input | 1 | Slave reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Master idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | AW | Word address |
| cmd_wdata | input | DW | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read word, valid with rsp_valid on reads |
| bus_addr_o | output | AW | Shared address lines |
| bus_write_o | output | 1 | Shared direction line |
| bus_req_o | output | 1 | Request strobe |
| bus_ack_o | output | 1 | Acknowledge strobe (OR of slaves) |
| bus_data_o | output | DW | Resolved shared data lines |

## Verification
The bench goes after the interlock. It watches every change of request and acknowledge, so a slave that drops acknowledge before request falls, or a master that drops request early, shows up as an out-of-order edge. It measures the gap from address to request in cycles; a settle counter that is off by one gives a wrong count. It holds a second command valid while the first is still in flight; a ready that leaks during a busy exchange would take that command twice or corrupt the scoreboard order. It also checks that the data lines read zero outside a read acknowledge, which catches a slave that drives the bus too early or leaves it driven, and it writes to both edges of both windows to catch a wrong slave-select split.

// File: rtl/asb_pkg.sv
package asb_pkg;
  typedef enum logic [1:0] {
    M_IDLE     = 2'd0,
    M_SETTLE   = 2'd1,
    M_WAIT_ACK = 2'd2,
    M_WAIT_REL = 2'd3
  } mst_state_e;
endpackage

// File: rtl/asb_sync.sv
module asb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/asb_master.sv
module asb_master
  import asb_pkg::*;
#(
  parameter int AW            = 8,
  parameter int DW            = 16,
  parameter int SETTLE_CYCLES = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic          bus_req,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_oe,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_ack
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  mst_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          wr_q, req_q, done_q, ack_sy, busy;

  asb_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_ack), .q(ack_sy)
  );

  assign busy = (state_q != M_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        M_IDLE: begin
          if (cmd_valid) begin
            addr_q  <= cmd_addr;
            wr_q    <= cmd_write;
            wdata_q <= cmd_wdata;
            cnt_q   <= '0;
            state_q <= M_SETTLE;
          end
        end
        M_SETTLE: begin
          if (cnt_q == LAST) begin
            req_q   <= 1'b1;
            state_q <= M_WAIT_ACK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        M_WAIT_ACK: begin
          if (ack_sy) begin
            req_q <= 1'b0;
            if (!wr_q) rdata_q <= bus_data_i;
            state_q <= M_WAIT_REL;
          end
        end
        M_WAIT_REL: begin
          if (!ack_sy) begin
            done_q  <= 1'b1;
            state_q <= M_IDLE;
          end
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign cmd_ready    = !busy;
  assign rsp_valid    = done_q;
  assign rsp_rdata    = rdata_q;
  assign bus_addr     = addr_q;
  assign bus_write    = wr_q;
  assign bus_req      = req_q;
  assign bus_wdata    = wdata_q;
  assign bus_wdata_oe = wr_q && busy;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_write))); // R3
  AST_REQ_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(busy) && $stable(bus_addr))); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !ack_sy) |=> bus_req); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!bus_req && !ack_sy)); // R9
endmodule

// File: rtl/asb_slave.sv
module asb_slave #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int DEPTH       = 16,
  parameter int SLV_ID      = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_write,
  input  logic          bus_req,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_ack,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rdata_oe
);
  localparam int IW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;
  logic          ack_q, req_sy, sel;
  logic [IW-1:0] idx;

  asb_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_req), .q(req_sy)
  );

  assign sel = (bus_addr[AW-1:IW] == (AW-IW)'(SLV_ID));
  assign idx = bus_addr[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      rd_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (!ack_q) begin
      if (req_sy && sel) begin
        if (bus_write) mem_q[idx] <= bus_wdata;
        else           rd_q       <= mem_q[idx];
        ack_q <= 1'b1;
      end
    end else if (!req_sy) begin
      ack_q <= 1'b0;
    end
  end

  assign bus_ack      = ack_q;
  assign bus_rdata    = rd_q;
  assign bus_rdata_oe = ack_q && sel && !bus_write;

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(req_sy)); // R7
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && req_sy) |=> bus_ack); // R7
  AST_ACK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(sel)); // R10
endmodule

// File: rtl/asb_link.sv
module asb_link #(
  parameter int AW            = 8,
  parameter int DW            = 16,
  parameter int SLV_DEPTH     = 16,
  parameter int NUM_SLV       = 2,
  parameter int SETTLE_CYCLES = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          clk_m,
  input  logic          rst_m_n,
  input  logic          clk_s,
  input  logic          rst_s_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_write_o,
  output logic          bus_req_o,
  output logic          bus_ack_o,
  output logic [DW-1:0] bus_data_o
);
  logic [AW-1:0]      b_addr;
  logic               b_write, b_req, m_oe;
  logic [DW-1:0]      m_wdata, b_data;
  logic [NUM_SLV-1:0] s_ack, s_oe;
  logic [DW-1:0]      s_rdata [NUM_SLV];

  asb_master #(
    .AW(AW), .DW(DW), .SETTLE_CYCLES(SETTLE_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_master (
    .clk(clk_m), .rst_n(rst_m_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr(b_addr), .bus_write(b_write), .bus_req(b_req),
    .bus_wdata(m_wdata), .bus_wdata_oe(m_oe),
    .bus_data_i(b_data), .bus_ack(bus_ack_o)
  );

  for (genvar g = 0; g < NUM_SLV; g++) begin : g_slv
    asb_slave #(
      .AW(AW), .DW(DW), .DEPTH(SLV_DEPTH), .SLV_ID(g), .SYNC_STAGES(SYNC_STAGES)
    ) u_slave (
      .clk(clk_s), .rst_n(rst_s_n),
      .bus_addr(b_addr), .bus_write(b_write), .bus_req(b_req),
      .bus_wdata(b_data), .bus_ack(s_ack[g]),
      .bus_rdata(s_rdata[g]), .bus_rdata_oe(s_oe[g])
    );
  end

  // Open-drain style resolution: undriven lines read zero
  always_comb begin
    b_data = m_oe ? m_wdata : '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      if (s_oe[i]) b_data = b_data | s_rdata[i];
    end
  end

  assign bus_ack_o   = |s_ack;
  assign bus_addr_o  = b_addr;
  assign bus_write_o = b_write;
  assign bus_req_o   = b_req;
  assign bus_data_o  = b_data;

  AST_ONE_DRIVER: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $onehot0({m_oe, s_oe})); // R8
  AST_ONE_ACK: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $onehot0(s_ack)); // R10
endmodule

// File: tb/asb_link_tb_top.sv
module asb_link_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int SLV_DEPTH = 16;
  localparam int NUM_SLV = 2;
  localparam int SETTLE = 2;
  localparam int NWORDS = SLV_DEPTH * NUM_SLV;

  logic clk_m = 1'b0, clk_s = 1'b0;
  logic rst_m_n = 1'b0, rst_s_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, bus_write_o, bus_req_o, bus_ack_o;
  logic [DW-1:0] rsp_rdata, bus_data_o;
  logic [AW-1:0] bus_addr_o;

  always #5 clk_m = ~clk_m;
  always #6.5 clk_s = ~clk_s;

  asb_link #(.AW(AW), .DW(DW), .SLV_DEPTH(SLV_DEPTH), .NUM_SLV(NUM_SLV),
             .SETTLE_CYCLES(SETTLE), .SYNC_STAGES(2)) dut_i (
    .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .bus_addr_o(bus_addr_o), .bus_write_o(bus_write_o), .bus_req_o(bus_req_o),
    .bus_ack_o(bus_ack_o), .bus_data_o(bus_data_o)
  );

  int n_chk = 0, n_bad = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [DW-1:0] model [NWORDS];
  logic [DW-1:0] exp_data [$];
  bit            exp_rd [$];
  string         exp_tag [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Driver: raises valid at once, holds it while ready is low (back-pressure)
  task automatic issue(input bit wr, input int addr, input logic [DW-1:0] wd,
                       input string tag);
    int n;
    @(negedge clk_m);
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_addr  = AW'(addr);
    cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk_m);
    if (wr) model[addr] = wd;
    exp_rd.push_back(!wr);
    exp_data.push_back(wr ? '0 : model[addr]);
    exp_tag.push_back(tag);
    @(negedge clk_m);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R2", "ready after accept", 32'(cmd_ready), 0);
    chk(bus_addr_o == AW'(addr), "R3", "bus address", 32'(bus_addr_o), 32'(addr));
    chk(bus_write_o == wr, "R3", "bus direction", 32'(bus_write_o), 32'(wr));
    n = 0;
    while (!bus_req_o && n < 1000) begin
      n++;
      @(negedge clk_m);
    end
    chk(n == SETTLE, "R4", "settle cycles before req", 32'(n), 32'(SETTLE));
  endtask

  task automatic wait_idle();
    while (!cmd_ready || exp_rd.size() != 0) @(negedge clk_m);
  endtask

  // Monitor: scoreboard pop plus protocol ordering
  logic prev_req = 1'b0, prev_ack = 1'b0, prev_rsp = 1'b0, prev_rdy = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  logic prev_wr = 1'b0;
  logic [DW-1:0] prev_data = '0;

  always @(negedge clk_m) begin
    if (mon_on) begin
      if (rsp_valid) begin
        if (exp_rd.size() == 0) begin
          chk(1'b0, "R2", "unexpected completion", 1, 0);
        end else begin
          bit rd;
          logic [DW-1:0] ed;
          string tg;
          rd = exp_rd.pop_front();
          ed = exp_data.pop_front();
          tg = exp_tag.pop_front();
          if (rd) chk(rsp_rdata == ed, tg, "read word", 32'(rsp_rdata), 32'(ed));
        end
        chk(!bus_req_o && !bus_ack_o, "R9", "strobes low at done",
            32'({bus_req_o, bus_ack_o}), 0);
        chk(!prev_rsp, "R9", "done pulse width", 32'(prev_rsp), 0);
      end
      if (!prev_ack && bus_ack_o)
        chk(bus_req_o, "R7", "ack rose without req", 32'(bus_req_o), 1);
      if (prev_req && !bus_req_o)
        chk(bus_ack_o, "R7", "req fell before ack", 32'(bus_ack_o), 1);
      if (prev_ack && !bus_ack_o)
        chk(!bus_req_o, "R7", "ack fell while req high", 32'(bus_req_o), 0);
      if (!bus_ack_o && !bus_write_o)
        chk(bus_data_o == '0, "R8", "data lines driven outside read ack",
            32'(bus_data_o), 0);
      if (!cmd_ready && !prev_rdy) begin
        if (bus_addr_o != prev_addr || bus_write_o != prev_wr)
          chk(1'b0, "R3", "address moved mid transfer", 32'(bus_addr_o), 32'(prev_addr));
        if (bus_write_o && bus_data_o != prev_data)
          chk(1'b0, "R3", "write data moved mid transfer", 32'(bus_data_o), 32'(prev_data));
      end
    end
    prev_req  = bus_req_o;
    prev_ack  = bus_ack_o;
    prev_rsp  = rsp_valid;
    prev_rdy  = cmd_ready;
    prev_addr = bus_addr_o;
    prev_wr   = bus_write_o;
    prev_data = bus_data_o;
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk_m) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < NWORDS; i++) model[i] = '0;
    repeat (4) @(negedge clk_m);
    chk(cmd_ready == 1'b1, "R1", "ready in reset", 32'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
    chk(!bus_req_o && !bus_ack_o, "R1", "strobes in reset",
        32'({bus_req_o, bus_ack_o}), 0);
    rst_m_n = 1'b1;
    rst_s_n = 1'b1;
    @(negedge clk_m);
    chk(cmd_ready && !rsp_valid && !bus_req_o && !bus_ack_o, "R1",
        "state after reset", 32'({cmd_ready, rsp_valid, bus_req_o, bus_ack_o}), 32'h8);
    mon_on = 1'b1;

    // R5 / R10: one word in each window, then read back
    issue(1'b1, 3,  16'hA5A5, "R5");  wait_idle();
    issue(1'b1, 19, 16'h3C3C, "R10"); wait_idle();
    issue(1'b0, 3,  '0, "R10");       wait_idle();
    issue(1'b0, 19, '0, "R10");       wait_idle();
    // R6: never-written location reads zero
    issue(1'b0, 7,  '0, "R6");        wait_idle();
    // R10: window edges
    issue(1'b1, 0,  16'h0F01, "R10");
    issue(1'b1, 15, 16'h0F0F, "R10");
    issue(1'b1, 16, 16'h1010, "R10");
    issue(1'b1, 31, 16'h1F1F, "R10");
    issue(1'b0, 0,  '0, "R10");
    issue(1'b0, 15, '0, "R10");
    issue(1'b0, 16, '0, "R10");
    issue(1'b0, 31, '0, "R10");
    wait_idle();
    // R2 / R6: back-to-back commands held valid under back-pressure
    for (int i = 0; i < 12; i++)
      issue(1'b1, i * 2 + 1, DW'(16'h1357 * (i + 1)), "R5");
    for (int i = 0; i < 12; i++)
      issue(1'b0, i * 2 + 1, '0, "R6");
    wait_idle();
    // R5: overwrite then read
    issue(1'b1, 3, 16'hBEEF, "R5");
    issue(1'b0, 3, '0, "R5");
    issue(1'b0, 19, '0, "R10");
    wait_idle();
    repeat (5) @(negedge clk_m);
    chk(exp_rd.size() == 0, "R2", "pending completions", 32'(exp_rd.size()), 0);
    chk(cmd_ready && !rsp_valid, "R9", "idle at end",
        32'({cmd_ready, rsp_valid}), 32'h2);
    summary();
  end
endmodule